// File: doc/BRIEF.md
# Multiplexed DAC Refresh Sequencer

This block keeps eight analog control voltages alive from a single serial DAC. One DAC output feeds an analog multiplexer, and each multiplexer channel charges its own hold capacitor. The block holds one 12-bit code per channel, which a host sets through a simple write port. It then visits the channels in a fixed round-robin order, with no further help from the host.

For each channel the block does four things in order. It puts the channel number on the select lines. It shifts that channel's code into the DAC over a clock, data and active-low strobe link. It waits for the DAC output to settle. It then raises the sample enable for a fixed charging window, and lowers it before the next channel is chosen.

The channel roles are fixed:

| Channel | Controls |
|---|---|
| 0 | display contrast |
| 1 | multiplier null |
| 2 | amplitude |
| 3 | offset |
| 4 | leading-edge time |
| 5 | trailing-edge time |
| 6 | duty-cycle threshold |
| 7 | timebase calibration |

The settle and sample intervals are given in nanoseconds. The block converts them to clock cycles from the clock-frequency parameter and rounds up, so neither interval comes out short. At 250 MHz the settle time is 375 cycles and the sample window is 3175 cycles.

Top module: `dac_refresh_seq`

## Requirements
- R1: Synchronous reset gives these values on the first clock after reset is released: `sel` = 0, `smpl_en` = 0, `dac_ld_n` = 1, `dac_sclk` = 0. Every stored code is mid-scale (12'h800), so the first word shifted out after reset is 12'h800 for channel 0.
- R2: `sel` visits the channels in the order 0,1,2,...,7,0 and so on. Each change of `sel` moves it up by one, and the value 7 wraps to 0.
- R3: Each serial word works as follows:
  - `dac_ld_n` stays low for the whole word.
  - `dac_sclk` gives exactly 12 rising edges while `dac_ld_n` is low, and stays low whenever `dac_ld_n` is high.
  - The bits go out MSB first and are valid on the rising edge of `dac_sclk`.
  - `dac_sdata` changes only in a cycle where `dac_sclk` falls or `dac_ld_n` falls.
- R4: The word shifted while `dac_ld_n` is low equals the stored code of the channel on `sel`. `sel` takes its new value before `dac_ld_n` falls and holds it through the whole word.
- R5: `smpl_en` rises exactly SETTLE_CYC = ceil(SETTLE_NS × CLK_HZ / 1e9) clock cycles after `dac_ld_n` returns high. This is 375 cycles at the default settings. `smpl_en` is never high while `dac_ld_n` is low.
- R6: `smpl_en` stays high for exactly SAMPLE_CYC = ceil(SAMPLE_NS × CLK_HZ / 1e9) cycles, which is 3175 cycles at the default settings.
- R7: `sel` never changes while `smpl_en` is high, or in the same cycle that `smpl_en` falls. It changes only after `smpl_en` has been low for at least one clock.
- R8: A host write (`wr_en` = 1 with `wr_ch` and `wr_code`) stores the code at the next clock edge. The next word started for that channel uses the new code.
- R9: A write to a channel whose word is being shifted does not change the word in progress. The new code first appears on the following pass.
- R10: Refresh runs continuously with no host action. Channel passes keep following one another for as long as reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the code registers |
| wr_ch | input | 3 | Channel number to write |
| wr_code | input | 12 | Code to store for `wr_ch` |
| sel | output | 3 | Select for the track-and-hold multiplexer |
| dac_sclk | output | 1 | Serial clock to the DAC, idle low |
| dac_sdata | output | 1 | Serial data to the DAC, MSB first |
| dac_ld_n | output | 1 | DAC strobe, active low; low for the whole word, and the rising edge latches it |
| smpl_en | output | 1 | Sample enable for the selected hold channel |

## Verification
The pins show a wrong sequencer state within one channel slot, about 3600 cycles. Three kinds of fault can occur:
- A wrong channel count appears as a `sel` step other than +1.
- A bad shift register or bit counter gives a wrong word, or a bit count other than 12, when `dac_ld_n` rises.
- A timer that is off by one shifts the edge of `smpl_en` by a single cycle against the computed count.

The host model is checked twice per write. A write that lands during the shift must leave that word unchanged. The next pass for that channel must then show the new code.

// File: rtl/dacseq_pkg.sv
// Package: shared state type and cycle-count helper for the DAC refresh sequencer.
// Assumes: all timing parameters are non-negative and small enough for 64-bit math.
package dacseq_pkg;

    typedef enum logic [2:0] {
        SQ_LOAD   = 3'd0,
        SQ_SHIFT  = 3'd1,
        SQ_SETTLE = 3'd2,
        SQ_SAMPLE = 3'd3,
        SQ_GAP    = 3'd4
    } seq_state_t;

    // Converts a duration in ns to clock cycles, rounding up
    function automatic longint ns_to_cycles(input longint ns, input longint hz);
        return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/dacseq_regfile.sv
// Module: code storage, one register per hold channel.
// What it does: keeps a code for each channel, takes host writes and gives the
//   code of one channel through a read port.
// Assumes: one write per cycle at most; a write becomes visible on the next cycle.
module dacseq_regfile #(
    parameter int          NCH        = 8,
    parameter int          CODE_W     = 12,
    parameter logic [11:0] RESET_CODE = 12'h800,
    localparam int         CH_W       = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] codes [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Holds the stored code of channel g
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[g] <= CODE_W'(RESET_CODE);
            else if (wr_en && (wr_ch == CH_W'(g)))
                codes[g] <= wr_code;
        end
    end

    // Gives the code of the channel on the read port
    always_comb begin
        rd_code = codes[rd_ch];
    end

endmodule

// File: rtl/dacseq_shifter.sv
// Module: three-wire serial word transmitter for the DAC.
// What it does: on start, copies the code, pulls the strobe low and sends
//   CODE_W bits MSB first. Data changes on falling sclk and is valid on rising
//   sclk. After one low tail half-period it raises the strobe.
// Assumes: start is seen only while idle; HALF_CYC >= 1.
module dacseq_shifter #(
    parameter int CODE_W   = 12,
    parameter int HALF_CYC = 2,
    localparam int HALVES  = 2 * CODE_W,
    localparam int HC_W    = $clog2(HALVES + 1),
    localparam int DIV_W   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              sclk,
    output logic              sdata,
    output logic              ld_n,
    output logic              done
);

    logic              busy;
    logic [DIV_W-1:0]  div_cnt;
    logic [HC_W-1:0]   half_cnt;
    logic [CODE_W-1:0] shreg;
    logic              tick;

    // Marks the last cycle of each half-period
    always_comb begin
        tick = (div_cnt == DIV_W'(HALF_CYC - 1));
    end

    // Flags the final cycle of the tail, one cycle before the strobe rises
    always_comb begin
        done = busy && tick && (half_cnt == HC_W'(HALVES));
    end

    // Drives the serial lines through all the half-periods of a word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ld_n     <= 1'b1;
            sclk     <= 1'b0;
            shreg    <= '0;
            div_cnt  <= '0;
            half_cnt <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                ld_n     <= 1'b0;
                shreg    <= code;
                div_cnt  <= '0;
                half_cnt <= '0;
            end
        end else if (tick) begin
            div_cnt <= '0;
            if (half_cnt == HC_W'(HALVES)) begin
                busy <= 1'b0;
                ld_n <= 1'b1;
            end else begin
                half_cnt <= half_cnt + 1'b1;
                sclk     <= ~sclk;
                if (sclk)
                    shreg <= {shreg[CODE_W-2:0], 1'b0};
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Presents the current MSB on the data line
    always_comb begin
        sdata = shreg[CODE_W-1];
    end

endmodule

// File: rtl/dacseq_timer.sv
// Module: interval counter for the settle and sample windows.
// What it does: after a clear, counts cycles and flags the last cycle of a
//   window whose length is chosen per use.
// Assumes: the length is at least 1 and fits in CNT_W bits.
module dacseq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] length,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Counts cycles since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Flags the cycle in which the window ends
    always_comb begin
        last = (cnt == length - 1'b1);
    end

endmodule

// File: rtl/dac_refresh_seq.sv
// Module: top of the multiplexed DAC refresh sequencer.
// What it does: for each channel in turn it sets sel, sends the stored code
//   to the DAC, waits SETTLE_CYC cycles, pulses smpl_en for SAMPLE_CYC
//   cycles, then waits one idle cycle and steps to the next channel.
// Assumes: NCH is a power of two; CLK_HZ is the real frequency of clk.
module dac_refresh_seq #(
    parameter longint CLK_HZ    = 250_000_000,
    parameter int     NCH       = 8,
    parameter int     CODE_W    = 12,
    parameter int     SCLK_HALF = 2,
    parameter longint SETTLE_NS = 1500,
    parameter longint SAMPLE_NS = 12700,
    localparam int    CH_W      = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CH_W-1:0]   sel,
    output logic              dac_sclk,
    output logic              dac_sdata,
    output logic              dac_ld_n,
    output logic              smpl_en
);
    import dacseq_pkg::*;

    localparam int SETTLE_CYC = int'(ns_to_cycles(SETTLE_NS, CLK_HZ));
    localparam int SAMPLE_CYC = int'(ns_to_cycles(SAMPLE_NS, CLK_HZ));
    localparam int MAX_CYC    = (SETTLE_CYC > SAMPLE_CYC) ? SETTLE_CYC : SAMPLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t        state;
    logic [CH_W-1:0]   ch;
    logic [CODE_W-1:0] cur_code;
    logic              ld_done;
    logic              tmr_clear;
    logic              tmr_last;
    logic [CNT_W-1:0]  tmr_len;

    dacseq_regfile #(
        .NCH        (NCH),
        .CODE_W     (CODE_W),
        .RESET_CODE (12'h800)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_code (wr_code),
        .rd_ch   (ch),
        .rd_code (cur_code)
    );

    dacseq_shifter #(
        .CODE_W   (CODE_W),
        .HALF_CYC (SCLK_HALF)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == SQ_LOAD),
        .code  (cur_code),
        .sclk  (dac_sclk),
        .sdata (dac_sdata),
        .ld_n  (dac_ld_n),
        .done  (ld_done)
    );

    dacseq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .length (tmr_len),
        .last   (tmr_last)
    );

    // Chooses the window length and restarts the timer at each phase change
    always_comb begin
        tmr_len   = (state == SQ_SAMPLE) ? CNT_W'(SAMPLE_CYC) : CNT_W'(SETTLE_CYC);
        tmr_clear = (state == SQ_SHIFT) || ((state == SQ_SETTLE) && tmr_last);
    end

    // Steps the per-channel phases and the channel index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_LOAD;
            ch      <= '0;
            smpl_en <= 1'b0;
        end else begin
            unique case (state)
                SQ_LOAD:   state <= SQ_SHIFT;
                SQ_SHIFT:  if (ld_done) state <= SQ_SETTLE;
                SQ_SETTLE: if (tmr_last) begin
                    state   <= SQ_SAMPLE;
                    smpl_en <= 1'b1;
                end
                SQ_SAMPLE: if (tmr_last) begin
                    state   <= SQ_GAP;
                    smpl_en <= 1'b0;
                end
                SQ_GAP: begin
                    ch    <= (ch == CH_W'(NCH - 1)) ? '0 : ch + 1'b1;
                    state <= SQ_LOAD;
                end
                default:   state <= SQ_LOAD;
            endcase
        end
    end

    // Drives the multiplexer select from the channel index
    always_comb begin
        sel = ch;
    end

endmodule

// File: rtl/dac_refresh_seq_chk.sv
// Module: assertion checker for dac_refresh_seq, attached through bind.
// What it does: checks the serial framing, channel order, select stability and
//   the two timed windows; the windows are measured with counters.
// Assumes: the parameters match those of the bound instance.
module dac_refresh_seq_chk #(
    parameter int NCH        = 8,
    parameter int SETTLE_CYC = 375,
    parameter int SAMPLE_CYC = 3175,
    localparam int CH_W      = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CH_W-1:0] sel,
    input logic            dac_sclk,
    input logic            dac_sdata,
    input logic            dac_ld_n,
    input logic            smpl_en
);

    logic        ld_q, sm_q;
    logic [31:0] since_ld, hi_len;

    // Measures the cycles since the strobe rose and since the enable rose
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q     <= 1'b1;
            sm_q     <= 1'b0;
            since_ld <= '0;
            hi_len   <= '0;
        end else begin
            ld_q <= dac_ld_n;
            sm_q <= smpl_en;
            if (dac_ld_n && !ld_q)
                since_ld <= 32'd1;
            else if (since_ld != '1)
                since_ld <= since_ld + 1'b1;
            if (smpl_en && !sm_q)
                hi_len <= 32'd1;
            else if (smpl_en)
                hi_len <= hi_len + 1'b1;
        end
    end

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_ld_n |-> !dac_sclk); // R3
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_sdata) |-> ($fell(dac_sclk) || $fell(dac_ld_n))); // R3
    AST_SEL_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_ld_n && !$fell(dac_ld_n)) |-> $stable(sel)); // R4
    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> (sel == (($past(sel) == CH_W'(NCH - 1)) ? '0 : $past(sel) + 1'b1))); // R2
    AST_NO_SMPL_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> !smpl_en); // R5
    AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smpl_en) |-> (since_ld == 32'(SETTLE_CYC))); // R5
    AST_SAMPLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smpl_en) |-> (hi_len == 32'(SAMPLE_CYC))); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> (!smpl_en && !$past(smpl_en))); // R7

endmodule

bind dac_refresh_seq dac_refresh_seq_chk #(
    .NCH        (NCH),
    .SETTLE_CYC (SETTLE_CYC),
    .SAMPLE_CYC (SAMPLE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .dac_sclk  (dac_sclk),
    .dac_sdata (dac_sdata),
    .dac_ld_n  (dac_ld_n),
    .smpl_en   (smpl_en)
);

// File: tb/dac_refresh_seq_test.sv
// Bench for dac_refresh_seq: random host writes with a fixed seed plus directed
// cases. A bench-side register model predicts every serial word.
`timescale 1ns/1ps
module dac_refresh_seq_test;

    localparam int SETTLE_EXP = 375;   // ceil(1500 ns * 250 MHz)
    localparam int SAMPLE_EXP = 3175;  // ceil(12700 ns * 250 MHz)
    localparam int LOADS_END  = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ch = '0;
    logic [11:0] wr_code = '0;
    logic [2:0]  sel;
    logic        dac_sclk, dac_sdata, dac_ld_n, smpl_en;

    int checks = 0;
    int errors = 0;

    dac_refresh_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
        .sel(sel), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata),
        .dac_ld_n(dac_ld_n), .smpl_en(smpl_en)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench model of the code registers, with the value before each edge kept
    logic [11:0] shadow [8];
    logic [11:0] shadow_d [8];
    bit          written [8];
    always @(posedge clk) begin
        for (int i = 0; i < 8; i++) shadow_d[i] <= shadow[i];
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) shadow[i] <= 12'h800;
        end else if (wr_en) begin
            shadow[wr_ch] <= wr_code;
        end
    end

    // Collects the serial bits on the rising edges of sclk
    logic [11:0] rx_word = '0;
    int          rx_bits = 0;
    always @(posedge dac_sclk) begin
        if (!dac_ld_n) begin
            rx_word = {rx_word[10:0], dac_sdata};
            rx_bits++;
        end
    end

    // Port monitor: framing, order and timing, sampled at the falling clock edge
    int          loads = 0;
    logic        ld_p = 1'b1, sm_p = 1'b0;
    logic [2:0]  sel_p = '0;
    logic [11:0] exp_word = '0;
    logic [2:0]  exp_ch = '0;
    bit          exp_new = 0;
    int          since_ld = 0, hi_cnt = 0, since_lo = 0;
    int          r9_ch = -1;
    bit          r9_armed = 0;
    bit          first = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            since_ld++; hi_cnt++; since_lo++;
            if (ld_p && !dac_ld_n) begin
                exp_ch   = sel;
                exp_word = shadow_d[sel];
                exp_new  = written[sel];
                written[sel] = 0;
                rx_bits  = 0;
                loads++;
            end
            if (!ld_p && dac_ld_n) begin
                since_ld = 0;
                chk(rx_bits == 12, "R3 bit count", rx_bits, 12);
                if (first) begin
                    chk(rx_word == 12'h800 && exp_ch == 0, "R1 first word", rx_word, 12'h800);
                    first = 0;
                end else if (r9_armed && int'(exp_ch) == r9_ch) begin
                    chk(rx_word == exp_word, "R9 word kept during write", rx_word, exp_word);
                    r9_armed = 0;
                end else if (exp_new) begin
                    chk(rx_word == exp_word, "R8 new code used", rx_word, exp_word);
                end else begin
                    chk(rx_word == exp_word, "R4 word matches channel", rx_word, exp_word);
                end
            end
            if (!sm_p && smpl_en) begin
                chk(since_ld == SETTLE_EXP, "R5 settle cycles", since_ld, SETTLE_EXP);
                hi_cnt = 0;
            end
            if (sm_p && !smpl_en) begin
                chk(hi_cnt == SAMPLE_EXP, "R6 sample cycles", hi_cnt, SAMPLE_EXP);
                since_lo = 0;
            end
            if (sel != sel_p) begin
                chk(sel == sel_p + 3'd1, "R2 channel order", sel, sel_p + 3'd1);
                chk(!smpl_en && !sm_p && since_lo >= 1, "R7 select change timing", since_lo, 1);
            end
            ld_p = dac_ld_n; sm_p = smpl_en; sel_p = sel;
        end
    end

    task automatic host_write(input logic [2:0] c, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = c; wr_code = v;
        written[c] = 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Stimulus: reset checks, the directed write during a shift, then random writes
    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(dac_ld_n == 1'b1 && dac_sclk == 1'b0, "R1 strobe/sclk in reset", {dac_ld_n, dac_sclk}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel == 3'd0 && smpl_en == 1'b0, "R1 select and enable after reset", {sel, smpl_en}, 0);
        wait (loads == 3);
        r9_ch = sel; r9_armed = 1;
        host_write(sel, 12'h5A3);
        while (loads < LOADS_END) begin
            repeat (200 + ($urandom % 2000)) @(negedge clk);
            if (loads < LOADS_END)
                host_write(3'($urandom % 8), 12'($urandom));
        end
    end

    // Watchdog, end-of-run check and summary
    initial begin
        int cyc = 0;
        while (loads < LOADS_END + 1 && cyc < 195000) begin
            @(negedge clk);
            cyc++;
        end
        if (loads < LOADS_END + 1)
            chk(0, "R10 watchdog expired", loads, LOADS_END + 1);
        else
            chk(loads > 40, "R10 continuous refresh", loads, LOADS_END + 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule